// File: doc/BRIEF.md
# Clock-Crossing Byte Packet Bridge

This block carries radar results from a fast processing clock domain to an 8-bit synchronous-FIFO USB bridge chip that runs on its own slower clock. On the processing side, a range-ready strobe captures a data frame of range word, Doppler word, detection byte and stream enables. A separate request strobe captures a status vector. Each event becomes a toggle. In the USB domain a multi-stage synchronizer turns each toggle back into a one-cycle event, and that event sets a pending flag.

A write state machine picks up the pending flags and serializes either an 11-byte data packet or a 26-byte status packet, one byte per USB clock. A byte moves only when the chip reports transmit space. A separate read state machine takes 4-byte host commands from the chip's receive side. It assembles them into one word and pulses a completion flag.

All chip-side strobes are active-low.

Top module: `usb_pkt_bridge`

## Requirements
- R1: While either reset is asserted and right after it, `wr_n`, `rd_n` and `oe_n` are high and `cmd_done` is low.
- R2: A data packet has 11 bytes in this order:
  - byte 0 is 0xA5;
  - bytes 1 to 4 are the range word, most significant byte first;
  - bytes 5 to 8 are the Doppler word, most significant byte first;
  - byte 9 is the detection byte;
  - byte 10 is 0x5A.
- R3: `stream_en` bit 0 enables the range field, bit 1 the Doppler field and bit 2 the detection byte. A field whose bit is 0 is sent as zero bytes; the header and trailer are unaffected.
- R4: A status packet has 26 bytes: 0xC3, then the 24 bytes of `status_vec` most significant byte first, then 0x3C.
- R5: `wr_n` is low only while `tx_space_n` is low and a packet is in progress. A byte is transferred on each rising `usb_clk` edge where both are low. While `tx_space_n` is high, the byte position holds, so no byte is skipped or repeated.
- R6: Packets never interleave. A status request that arrives while a data packet is in progress is sent after that packet completes. When data and status are both pending, the data packet goes first.
- R7: Each range-ready pulse produces exactly one data packet. The strobe passes through one processing-clock register before its toggle is launched.
- R8: `rd_n` and `oe_n` are low together, and only while `rx_avail_n` is low. A byte is taken on each rising edge where `rd_n` is low.
- R9: Four taken bytes form `cmd_word`, with the first byte in bits 31:24. `cmd_done` is high for exactly one cycle, the cycle after the fourth byte is taken. During that cycle no byte is read.
- R10: A data event that arrives while a packet is in progress is held pending and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| proc_clk | input | 1 | Processing-domain clock |
| proc_rst_n | input | 1 | Processing-domain asynchronous reset, active low |
| range_ready | input | 1 | One-cycle strobe that captures a data frame |
| range_word | input | 32 | Range field of the frame |
| doppler_word | input | 32 | Doppler field of the frame |
| detect_byte | input | 8 | Detection field of the frame |
| stream_en | input | 3 | Field enables: bit 0 range, bit 1 Doppler, bit 2 detection |
| status_req | input | 1 | One-cycle strobe that captures a status vector |
| status_vec | input | 192 | Status payload |
| usb_clk | input | 1 | USB-chip clock |
| usb_rst_n | input | 1 | USB-domain asynchronous reset, active low |
| tx_space_n | input | 1 | Low when the chip can accept a byte |
| wr_n | output | 1 | Write strobe, active low |
| tx_byte | output | 8 | Outgoing byte |
| rx_avail_n | input | 1 | Low when the chip holds a byte for reading |
| rd_n | output | 1 | Read strobe, active low |
| oe_n | output | 1 | Chip output enable, active low |
| rx_byte | input | 8 | Incoming byte |
| cmd_word | output | 32 | Last complete command |
| cmd_done | output | 1 | One-cycle pulse when a command completes |

## Verification
The assertions assume that the frame and status inputs stay unchanged from their capture until the packet that carries them has been sent. They also assume that the strobes on the processing side are spaced far enough apart for every toggle to be seen in the USB domain. Finally, they assume that `tx_space_n` and `rx_avail_n` change only between USB clock edges.

The bench drives every input at a falling edge and spaces events by tens of cycles. When two data events overlap a stalled packet, it reuses the same frame values. It stalls the transmit side on an irregular pattern to exercise the hold behaviour.

// File: rtl/usb_bridge_pkg.sv
package usb_bridge_pkg;
  localparam int DATA_LEN    = 11;
  localparam int STAT_LEN    = 26;
  localparam int STAT_BODY   = STAT_LEN - 2;
  localparam int STAT_W      = 8 * STAT_BODY;
  localparam int IDX_W       = $clog2(STAT_LEN);

  localparam logic [7:0] DATA_HEAD = 8'hA5;
  localparam logic [7:0] DATA_TAIL = 8'h5A;
  localparam logic [7:0] STAT_HEAD = 8'hC3;
  localparam logic [7:0] STAT_TAIL = 8'h3C;

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_STAT} tx_state_e;

  typedef struct packed {
    logic [31:0] rng;
    logic [31:0] dop;
    logic [7:0]  det;
    logic [2:0]  en;
  } frame_t;

  // Byte at position idx of a data packet; disabled fields read as zero.
  function automatic logic [7:0] data_byte(input logic [IDX_W-1:0] idx, input frame_t f);
    logic [31:0] r;
    logic [31:0] d;
    logic [7:0]  t;
    r = f.en[0] ? f.rng : '0;
    d = f.en[1] ? f.dop : '0;
    t = f.en[2] ? f.det : '0;
    case (idx)
      5'd0:    return DATA_HEAD;
      5'd1:    return r[31:24];
      5'd2:    return r[23:16];
      5'd3:    return r[15:8];
      5'd4:    return r[7:0];
      5'd5:    return d[31:24];
      5'd6:    return d[23:16];
      5'd7:    return d[15:8];
      5'd8:    return d[7:0];
      5'd9:    return t;
      5'd10:   return DATA_TAIL;
      default: return 8'h00;
    endcase
  endfunction

  // Byte at position idx of a status packet; body is sent MSB first.
  function automatic logic [7:0] status_byte(input logic [IDX_W-1:0] idx,
                                             input logic [STAT_W-1:0] v);
    logic [STAT_W-1:0] s;
    if (idx == '0) return STAT_HEAD;
    if (int'(idx) == STAT_LEN - 1) return STAT_TAIL;
    s = v >> (8 * (STAT_BODY - int'(idx)));
    return s[7:0];
  endfunction
endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], tog_in};
  end

  assign pulse = sh[STAGES-1] ^ sh[STAGES-2];
endmodule

// File: rtl/proc_capture.sv
module proc_capture
  import usb_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              range_ready,
  input  frame_t            frame_in,
  input  logic              status_req,
  input  logic [STAT_W-1:0] status_in,
  output frame_t            frame_hold,
  output logic [STAT_W-1:0] stat_hold,
  output logic              data_tog,
  output logic              stat_tog
);
  logic ready_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_d    <= 1'b0;
      frame_hold <= '0;
      stat_hold  <= '0;
      data_tog   <= 1'b0;
      stat_tog   <= 1'b0;
    end else begin
      ready_d <= range_ready;
      if (range_ready) frame_hold <= frame_in;
      if (ready_d)     data_tog   <= ~data_tog;   // R7: launched one cycle late
      if (status_req) begin
        stat_hold <= status_in;
        stat_tog  <= ~stat_tog;
      end
    end
  end
endmodule

// File: rtl/tx_engine.sv
module tx_engine
  import usb_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_evt,
  input  logic              stat_evt,
  input  frame_t            frame,
  input  logic [STAT_W-1:0] stat_vec,
  input  logic              tx_space_n,
  output logic              wr_n,
  output logic [7:0]        tx_byte
);
  tx_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             data_pend, stat_pend;
  logic             accept, last, launch_data, launch_stat;

  assign accept      = (state != TX_IDLE) && !tx_space_n;
  assign last        = accept && (idx == ((state == TX_DATA) ? IDX_W'(DATA_LEN - 1)
                                                             : IDX_W'(STAT_LEN - 1)));
  assign launch_data = (state == TX_IDLE) && data_pend;
  assign launch_stat = (state == TX_IDLE) && !data_pend && stat_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      idx       <= '0;
      data_pend <= 1'b0;
      stat_pend <= 1'b0;
    end else begin
      data_pend <= data_evt | (data_pend & ~launch_data);
      stat_pend <= stat_evt | (stat_pend & ~launch_stat);
      case (state)
        TX_IDLE: begin
          idx <= '0;
          if (launch_data)      state <= TX_DATA;
          else if (launch_stat) state <= TX_STAT;
        end
        default: begin
          if (last) begin
            state <= TX_IDLE;
            idx   <= '0;
          end else if (accept) begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  assign wr_n    = !accept;
  assign tx_byte = (state == TX_STAT) ? status_byte(idx, stat_vec) : data_byte(idx, frame);

  assert_wr_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !tx_space_n);
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != TX_IDLE && tx_space_n) |=> (idx == $past(idx)));
  assert_no_interleave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != TX_IDLE && !last) |=> (state == $past(state)));
  assert_data_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE && data_pend) |=> (state == TX_DATA));
endmodule

// File: rtl/rx_engine.sv
module rx_engine #(
  parameter int CMD_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_avail_n,
  input  logic [7:0]             rx_byte,
  output logic                   rd_n,
  output logic                   oe_n,
  output logic [8*CMD_BYTES-1:0] cmd_word,
  output logic                   cmd_done
);
  localparam int CNT_W = $clog2(CMD_BYTES);
  localparam int SH_W  = 8 * CMD_BYTES;

  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  shreg;
  logic             take;

  assign take = !rx_avail_n && !cmd_done;
  assign rd_n = !take;
  assign oe_n = !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      cmd_word <= '0;
      cmd_done <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      if (take) begin
        shreg <= {shreg[SH_W-9:0], rx_byte};
        if (cnt == CNT_W'(CMD_BYTES - 1)) begin
          cnt      <= '0;
          cmd_word <= {shreg[SH_W-9:0], rx_byte};
          cmd_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_rd_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !rx_avail_n);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  assert_word_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word != $past(cmd_word)) |-> cmd_done);
endmodule

// File: rtl/usb_pkt_bridge.sv
module usb_pkt_bridge
  import usb_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int CMD_BYTES   = 4
) (
  input  logic                   proc_clk,
  input  logic                   proc_rst_n,
  input  logic                   range_ready,
  input  logic [31:0]            range_word,
  input  logic [31:0]            doppler_word,
  input  logic [7:0]             detect_byte,
  input  logic [2:0]             stream_en,
  input  logic                   status_req,
  input  logic [STAT_W-1:0]      status_vec,
  input  logic                   usb_clk,
  input  logic                   usb_rst_n,
  input  logic                   tx_space_n,
  output logic                   wr_n,
  output logic [7:0]             tx_byte,
  input  logic                   rx_avail_n,
  output logic                   rd_n,
  output logic                   oe_n,
  input  logic [7:0]             rx_byte,
  output logic [8*CMD_BYTES-1:0] cmd_word,
  output logic                   cmd_done
);
  frame_t            frame_in, frame_hold;
  logic [STAT_W-1:0] stat_hold;
  logic              data_tog, stat_tog, data_evt, stat_evt;

  assign frame_in = '{rng: range_word, dop: doppler_word, det: detect_byte, en: stream_en};

  proc_capture u_cap (
    .clk(proc_clk), .rst_n(proc_rst_n), .range_ready(range_ready), .frame_in(frame_in),
    .status_req(status_req), .status_in(status_vec), .frame_hold(frame_hold),
    .stat_hold(stat_hold), .data_tog(data_tog), .stat_tog(stat_tog));

  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
    .clk(usb_clk), .rst_n(usb_rst_n), .tog_in(data_tog), .pulse(data_evt));
  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_stat (
    .clk(usb_clk), .rst_n(usb_rst_n), .tog_in(stat_tog), .pulse(stat_evt));

  tx_engine u_tx (
    .clk(usb_clk), .rst_n(usb_rst_n), .data_evt(data_evt), .stat_evt(stat_evt),
    .frame(frame_hold), .stat_vec(stat_hold), .tx_space_n(tx_space_n),
    .wr_n(wr_n), .tx_byte(tx_byte));

  rx_engine #(.CMD_BYTES(CMD_BYTES)) u_rx (
    .clk(usb_clk), .rst_n(usb_rst_n), .rx_avail_n(rx_avail_n), .rx_byte(rx_byte),
    .rd_n(rd_n), .oe_n(oe_n), .cmd_word(cmd_word), .cmd_done(cmd_done));
endmodule

// File: tb/test_usb_pkt_bridge.sv
`timescale 1ns/1ps
module test_usb_pkt_bridge;
  logic proc_clk = 0, usb_clk = 0;
  logic proc_rst_n = 0, usb_rst_n = 0;
  logic range_ready = 0, status_req = 0;
  logic [31:0] range_word = 0, doppler_word = 0;
  logic [7:0] detect_byte = 0;
  logic [2:0] stream_en = 0;
  logic [191:0] status_vec = 0;
  logic tx_space_n = 0, rx_avail_n = 1;
  logic [7:0] rx_byte = 0;
  logic wr_n, rd_n, oe_n, cmd_done;
  logic [7:0] tx_byte;
  logic [31:0] cmd_word;

  always #4 usb_clk = ~usb_clk;    // 125 MHz
  always #5 proc_clk = ~proc_clk;

  usb_pkt_bridge i_usb_pkt_bridge (
    .proc_clk(proc_clk), .proc_rst_n(proc_rst_n), .range_ready(range_ready),
    .range_word(range_word), .doppler_word(doppler_word), .detect_byte(detect_byte),
    .stream_en(stream_en), .status_req(status_req), .status_vec(status_vec),
    .usb_clk(usb_clk), .usb_rst_n(usb_rst_n), .tx_space_n(tx_space_n), .wr_n(wr_n),
    .tx_byte(tx_byte), .rx_avail_n(rx_avail_n), .rd_n(rd_n), .oe_n(oe_n),
    .rx_byte(rx_byte), .cmd_word(cmd_word), .cmd_done(cmd_done));

  int checks = 0, failures = 0;
  logic [7:0] cap [0:127];
  int cap_n = 0, wr_bad = 0, rd_bad = 0, done_cnt = 0;

  // Chip model: observe strobes between edges; transfer happens at the next rising edge.
  always @(negedge usb_clk) begin
    #1;
    if (!wr_n && !tx_space_n && cap_n < 128) begin cap[cap_n] = tx_byte; cap_n++; end
    if (!wr_n && tx_space_n) wr_bad++;
    if ((!rd_n && rx_avail_n) || (rd_n != oe_n)) rd_bad++;
    if (cmd_done) done_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data(input int k, input logic [31:0] r, input logic [31:0] d,
                                          input logic [7:0] t, input logic [2:0] en);
    logic [87:0] p;
    p = {8'hA5, (en[0] ? r : 32'h0), (en[1] ? d : 32'h0), (en[2] ? t : 8'h0), 8'h5A};
    return p[87 - 8*k -: 8];
  endfunction

  function automatic logic [7:0] exp_stat(input int k, input logic [191:0] v);
    logic [207:0] p;
    p = {8'hC3, v, 8'h3C};
    return p[207 - 8*k -: 8];
  endfunction

  task automatic cmp_data(input int off, input string req);
    bit ok = 1; logic [7:0] a = 0, e = 0;
    for (int k = 0; k < 11; k++) begin
      if (ok && cap[off+k] !== exp_data(k, range_word, doppler_word, detect_byte, stream_en)) begin
        ok = 0; a = cap[off+k]; e = exp_data(k, range_word, doppler_word, detect_byte, stream_en);
      end
    end
    check(ok, req, "data packet byte", 64'(a), 64'(e));
  endtask

  task automatic cmp_stat(input int off, input string req);
    bit ok = 1; logic [7:0] a = 0, e = 0;
    for (int k = 0; k < 26; k++) begin
      if (ok && cap[off+k] !== exp_stat(k, status_vec)) begin
        ok = 0; a = cap[off+k]; e = exp_stat(k, status_vec);
      end
    end
    check(ok, req, "status packet byte", 64'(a), 64'(e));
  endtask

  task automatic fire_data(input logic [31:0] r, input logic [31:0] d, input logic [7:0] t,
                           input logic [2:0] en);
    @(negedge proc_clk);
    range_word = r; doppler_word = d; detect_byte = t; stream_en = en; range_ready = 1;
    @(negedge proc_clk);
    range_ready = 0;
  endtask

  task automatic fire_status(input logic [191:0] v);
    @(negedge proc_clk);
    status_vec = v; status_req = 1;
    @(negedge proc_clk);
    status_req = 0;
  endtask

  task automatic idle_usb(input int n);
    repeat (n) @(negedge usb_clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge usb_clk);
    rx_byte = b; rx_avail_n = 0;
    #1;
    while (rd_n) begin @(negedge usb_clk); #1; end
    @(posedge usb_clk);
  endtask

  task automatic rx_gap(input int n);
    @(negedge usb_clk); rx_avail_n = 1;
    repeat (n) @(negedge usb_clk);
  endtask

  task automatic t_reset;
    #1;
    check(wr_n === 1'b1, "R1", "wr_n in reset", 64'(wr_n), 64'd1);
    check(rd_n === 1'b1 && oe_n === 1'b1, "R1", "rd_n/oe_n in reset", 64'({rd_n, oe_n}), 64'd3);
    check(cmd_done === 1'b0, "R1", "cmd_done in reset", 64'(cmd_done), 64'd0);
  endtask

  task automatic t_data_basic;
    cap_n = 0;
    fire_data(32'h11223344, 32'hA0B0C0D0, 8'h7E, 3'b111);
    idle_usb(60);
    check(cap_n == 11, "R7", "byte count for one event", 64'(cap_n), 64'd11);
    cmp_data(0, "R2");
  endtask

  task automatic t_data_masked;
    cap_n = 0;
    fire_data(32'hDEADBEEF, 32'h01020304, 8'hFF, 3'b010);
    idle_usb(60);
    check(cap_n == 11, "R3", "byte count masked", 64'(cap_n), 64'd11);
    cmp_data(0, "R3");
  endtask

  task automatic t_status;
    cap_n = 0;
    fire_status({8{24'h5A1C3E}} ^ 192'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978);
    idle_usb(80);
    check(cap_n == 26, "R4", "status byte count", 64'(cap_n), 64'd26);
    cmp_stat(0, "R4");
  endtask

  task automatic t_stall;
    cap_n = 0; wr_bad = 0;
    fire_data(32'hCAFEF00D, 32'h89ABCDEF, 8'h42, 3'b111);
    for (int i = 0; i < 60; i++) begin
      @(negedge usb_clk);
      tx_space_n = (i % 3 == 1) || (i >= 10 && i < 16);
    end
    @(negedge usb_clk); tx_space_n = 0;
    idle_usb(40);
    check(cap_n == 11, "R5", "bytes under stalls", 64'(cap_n), 64'd11);
    cmp_data(0, "R5");
    check(wr_bad == 0, "R5", "wr_n low while no space", 64'(wr_bad), 64'd0);
  endtask

  task automatic t_order;
    cap_n = 0;
    @(negedge usb_clk); tx_space_n = 1;
    fire_data(32'h0BADF00D, 32'h55AA55AA, 8'h81, 3'b101);
    idle_usb(20);
    fire_status({6{32'h13579BDF}});
    idle_usb(10);
    fire_data(32'h0BADF00D, 32'h55AA55AA, 8'h81, 3'b101);
    idle_usb(20);
    @(negedge usb_clk); tx_space_n = 0;
    idle_usb(150);
    check(cap_n == 48, "R10", "total bytes for three events", 64'(cap_n), 64'd48);
    cmp_data(0, "R6");
    cmp_data(11, "R10");
    cmp_stat(22, "R6");
  endtask

  task automatic t_cmd;
    done_cnt = 0; rd_bad = 0;
    send_byte(8'h9A); rx_gap(3);
    send_byte(8'hBC); send_byte(8'h01); rx_gap(2);
    send_byte(8'hEF);
    rx_gap(4);
    check(cmd_word === 32'h9ABC01EF, "R9", "cmd word", 64'(cmd_word), 64'h9ABC01EF);
    check(done_cnt == 1, "R9", "done pulse count", 64'(done_cnt), 64'd1);
    done_cnt = 0;
    send_byte(8'h10); send_byte(8'h20); send_byte(8'h30); send_byte(8'h40);
    send_byte(8'h55); send_byte(8'h66); send_byte(8'h77); send_byte(8'h88);
    rx_gap(4);
    check(cmd_word === 32'h55667788, "R9", "second back-to-back cmd word", 64'(cmd_word), 64'h55667788);
    check(done_cnt == 2, "R9", "done pulses back-to-back", 64'(done_cnt), 64'd2);
    check(rd_bad == 0, "R8", "rd_n/oe_n gating", 64'(rd_bad), 64'd0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge usb_clk);
    t_reset();
    @(negedge proc_clk); proc_rst_n = 1;
    @(negedge usb_clk); usb_rst_n = 1;
    idle_usb(3);
    t_reset();
    t_data_basic();
    t_data_masked();
    t_status();
    t_stall();
    t_order();
    t_cmd();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule